// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block frees a two-wire serial bus whose data line is held low by a target that lost step in the middle of a byte. Raising `start_i` makes it sample both bus lines once they have passed through a two-flop synchronizer. If both lines already read high, the block reports completion at once and leaves the clock line untouched. Otherwise it clocks the bus by pulling SCL low and then releasing it, a fixed number of times. This shifts the stuck target through the rest of its byte so that it lets go of SDA.

After the last pulse the block releases SCL and watches both lines until they read high together, or until an idle-wait window expires. Completion is a one-cycle `done_o` pulse. When the window expired, `busy_err_o` is high in the same cycle. The block only ever pulls SCL toward ground and has no drive path to SDA. The pulse count is 9 by default. When the largest target packet is set to N bytes (N greater than 0), the count becomes 8·N+1. The clock rate, phase length and timeout are parameters given in microseconds and in clocks per microsecond.

Top module: `i2c_bus_unstick`

## Requirements
- R1: If synchronized SDA and SCL both read high when a start is taken, `done_o` pulses within 4 cycles with `busy_err_o` low, and `scl_pull_o` never rises.
- R2: With a line low at start, exactly P SCL pulses are produced. P = 9 when `MAX_XFER_BYTES` is 0, and P = 8·`MAX_XFER_BYTES`+1 otherwise.
- R3: Each pulse holds `scl_pull_o` high for exactly `PHASE_US`·`CLKS_PER_US` cycles. Each gap between pulses, and the release after the last pulse, lasts the same number of cycles.
- R4: After the last pulse, once both synchronized lines read high within the window, `done_o` pulses with `busy_err_o` low.
- R5: If both lines are not high within `TIMEOUT_US`·`CLKS_PER_US` cycles of the wait, `done_o` and `busy_err_o` pulse together. The pulse comes exactly `PHASE_US`·`CLKS_PER_US` + `TIMEOUT_US`·`CLKS_PER_US` cycles after the last fall of `scl_pull_o`.
- R6: `scl_pull_o` is high only during pulse low phases, is low in reset and idle, and the block has no output toward SDA.
- R7: `done_o` is high for exactly one cycle per recovery, and `busy_err_o` is never high without `done_o`.
- R8: A start raised while a recovery is running has no effect: the run keeps its pulse count and produces one `done_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a recovery (taken only when idle) |
| scl_i | input | 1 | SCL line level as read from the pad |
| sda_i | input | 1 | SDA line level as read from the pad |
| scl_pull_o | output | 1 | 1 = pull SCL low (open drain), 0 = release |
| done_o | output | 1 | One-cycle completion pulse |
| busy_err_o | output | 1 | With `done_o`: lines did not go idle in time |

## Verification
The bench builds two copies with 2 clocks per microsecond, 3 µs phases and a 40 µs window. This gives 6-cycle phases and an 80-cycle timeout, so every run, including a full timeout, takes a few hundred cycles. The copy with `MAX_XFER_BYTES` = 0 is swept over every release point of a model target: release after 1 to 11 pulses, plus no stuck line at all. This covers both sides of the 9-pulse boundary, a clock line held low, and a second start in the middle of a run. The copy with `MAX_XFER_BYTES` = 2 confirms the scaled count of 17 pulses.

// File: rtl/iru_pkg.sv
package iru_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_LOW,
    ST_HIGH,
    ST_WAIT
  } iru_state_e;

  // Pulses needed to walk a stuck target through its longest packet.
  function automatic int unsigned recovery_pulses(input int unsigned max_bytes);
    if (max_bytes == 0) recovery_pulses = 9;
    else                recovery_pulses = max_bytes * 8 + 1;
  endfunction

  // Microseconds to clock cycles.
  function automatic int unsigned us_to_cycles(input int unsigned us,
                                               input int unsigned clks_per_us);
    us_to_cycles = us * clks_per_us;
  endfunction

endpackage

// File: rtl/iru_sync.sv
module iru_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;  // idle bus reads high
      else        chain <= {chain[STAGES-2:0], async_i[b]};
    end
    assign sync_o[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/iru_timer.sv
module iru_timer #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [WIDTH-1:0] load_val_i,
  output logic             zero_o
);
  logic [WIDTH-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (load_i)      cnt <= load_val_i;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero_o = (cnt == '0);

  AST_TIMER_HOLDS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_o && !load_i) |=> zero_o);  // R3
endmodule

// File: rtl/i2c_bus_unstick.sv
module i2c_bus_unstick
  import iru_pkg::*;
#(
  parameter int unsigned CLKS_PER_US    = 100,
  parameter int unsigned PHASE_US       = 50,
  parameter int unsigned TIMEOUT_US     = 200000,
  parameter int unsigned MAX_XFER_BYTES = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_pull_o,
  output logic done_o,
  output logic busy_err_o
);
  localparam int unsigned PULSES    = recovery_pulses(MAX_XFER_BYTES);
  localparam int unsigned PHASE_CYC = us_to_cycles(PHASE_US, CLKS_PER_US);
  localparam int unsigned TO_CYC    = us_to_cycles(TIMEOUT_US, CLKS_PER_US);
  localparam int unsigned MAX_CYC   = (TO_CYC > PHASE_CYC) ? TO_CYC : PHASE_CYC;
  localparam int unsigned TMR_W     = $clog2(MAX_CYC + 1);
  localparam int unsigned PCNT_W    = $clog2(PULSES + 1);
  localparam logic [TMR_W-1:0]  PHASE_LOAD = TMR_W'(PHASE_CYC - 1);
  localparam logic [TMR_W-1:0]  TO_LOAD    = TMR_W'(TO_CYC - 1);
  localparam logic [PCNT_W-1:0] PULSE_LAST = PCNT_W'(PULSES);

  // Synchronized lines: bit 1 = SCL, bit 0 = SDA.
  logic [1:0] lines_sync;
  iru_sync #(.WIDTH(2), .STAGES(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({scl_i, sda_i}),
    .sync_o  (lines_sync)
  );

  iru_state_e        state_q, state_d;
  logic [PCNT_W-1:0] pulse_q, pulse_d;
  logic              tmr_load;
  logic [TMR_W-1:0]  tmr_val;
  logic              tmr_zero;
  logic              done_d, err_d;

  // Named internal events for checking.
  logic lines_high, phase_end, pulses_done, wait_expired, start_taken;
  assign lines_high   = &lines_sync;
  assign phase_end    = tmr_zero && (state_q == ST_LOW || state_q == ST_HIGH);
  assign pulses_done  = (pulse_q == PULSE_LAST);
  assign wait_expired = tmr_zero && (state_q == ST_WAIT);
  assign start_taken  = start_i && (state_q == ST_IDLE);

  iru_timer #(.WIDTH(TMR_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  always_comb begin
    state_d  = state_q;
    pulse_d  = pulse_q;
    tmr_load = 1'b0;
    tmr_val  = PHASE_LOAD;
    done_d   = 1'b0;
    err_d    = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = ST_CHECK;
      ST_CHECK: begin
        if (lines_high) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          pulse_d  = '0;
          tmr_load = 1'b1;
          state_d  = ST_LOW;
        end
      end
      ST_LOW: if (tmr_zero) begin
        pulse_d  = pulse_q + 1'b1;
        tmr_load = 1'b1;
        state_d  = ST_HIGH;
      end
      ST_HIGH: if (tmr_zero) begin
        tmr_load = 1'b1;
        if (pulses_done) begin
          tmr_val = TO_LOAD;
          state_d = ST_WAIT;
        end else begin
          state_d = ST_LOW;
        end
      end
      ST_WAIT: begin
        if (lines_high) begin
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end else if (tmr_zero) begin
          done_d  = 1'b1;
          err_d   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      pulse_q    <= '0;
      done_o     <= 1'b0;
      busy_err_o <= 1'b0;
    end else begin
      state_q    <= state_d;
      pulse_q    <= pulse_d;
      done_o     <= done_d;
      busy_err_o <= err_d;
    end
  end

  assign scl_pull_o = (state_q == ST_LOW);

  AST_PULSE_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_q <= PULSE_LAST);  // R2
  AST_WAIT_AFTER_ALL_PULSES: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT) |-> pulses_done);  // R2
  AST_PULL_ENDS_ON_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_pull_o) |-> $past(phase_end));  // R3
  AST_ERR_ONLY_AFTER_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_err_o) |-> $past(wait_expired));  // R5
  AST_NO_PULL_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !scl_pull_o);  // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);  // R7
  AST_ERR_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_err_o |-> done_o);  // R7
  AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !start_taken) |=> state_q != ST_CHECK);  // R8
endmodule

// File: tb/i2c_bus_unstick_test.sv
module iru_tb_mon #(
  parameter int PHASE = 6
) (
  input  logic clk,
  input  logic clr,
  input  logic drive,
  input  logic done,
  input  logic err,
  output int   pulses,
  output int   dones,
  output int   errs,
  output int   lo_bad,
  output int   hi_bad,
  output int   gap
);
  logic pd;
  int   cyc, run, last_fall;
  always @(negedge clk) begin
    if (clr) begin
      pulses = 0; dones = 0; errs = 0; lo_bad = 0; hi_bad = 0; gap = -1;
      cyc = 0; run = 0; last_fall = 0; pd = drive;
    end else begin
      cyc++;
      if (drive != pd) begin
        if (drive) begin
          pulses++;
          if (pulses > 1 && run != PHASE) hi_bad++;
        end else begin
          if (run != PHASE) lo_bad++;
          last_fall = cyc;
        end
        run = 1;
      end else begin
        run++;
      end
      if (done) begin
        dones++;
        if (err) errs++;
        gap = cyc - last_fall;
      end
      pd = drive;
    end
  end
endmodule

module i2c_bus_unstick_test;
  localparam int CPU = 2, PH_US = 3, TO_US = 40;
  localparam int PHASE = PH_US * CPU;
  localparam int TOC   = TO_US * CPU;

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b1;
  logic start1 = 1'b0, start2 = 1'b0;
  logic stuck1 = 1'b0, stuck2 = 1'b0, hold1 = 1'b0;
  int   rel1 = 0, rel2 = 0;
  logic drv1, done1, err1, drv2, done2, err2;
  int   p1, d1, e1, lb1, hb1, g1, p2, d2, e2, lb2, hb2, g2;
  int   checks = 0, errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  // Model target: holds SDA low until it has seen rel pulses.
  wire scl1 = !(drv1 || hold1);
  wire sda1 = !(stuck1 && p1 < rel1);
  wire scl2 = !drv2;
  wire sda2 = !(stuck2 && p2 < rel2);

  i2c_bus_unstick #(.CLKS_PER_US(CPU), .PHASE_US(PH_US), .TIMEOUT_US(TO_US),
                    .MAX_XFER_BYTES(0)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start1), .scl_i(scl1), .sda_i(sda1),
    .scl_pull_o(drv1), .done_o(done1), .busy_err_o(err1));
  i2c_bus_unstick #(.CLKS_PER_US(CPU), .PHASE_US(PH_US), .TIMEOUT_US(TO_US),
                    .MAX_XFER_BYTES(2)) uut2 (
    .clk(clk), .rst_n(rst_n), .start_i(start2), .scl_i(scl2), .sda_i(sda2),
    .scl_pull_o(drv2), .done_o(done2), .busy_err_o(err2));

  iru_tb_mon #(.PHASE(PHASE)) mon1 (.clk(clk), .clr(clr), .drive(drv1),
    .done(done1), .err(err1), .pulses(p1), .dones(d1), .errs(e1),
    .lo_bad(lb1), .hi_bad(hb1), .gap(g1));
  iru_tb_mon #(.PHASE(PHASE)) mon2 (.clk(clk), .clr(clr), .drive(drv2),
    .done(done2), .err(err2), .pulses(p2), .dones(d2), .errs(e2),
    .lo_bad(lb2), .hi_bad(hb2), .gap(g2));

  function automatic int exp_pulses(input int n);
    return 8 * n + 1 + ((n == 0) ? 8 : 0);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(posedge clk); #1 clr = 1'b1;
    @(posedge clk); #1 clr = 1'b0;
  endtask

  // Wait for a done on copy 1 (sel=0) or copy 2 (sel=1), then settle.
  task automatic wait_done(input int sel, input int limit, output int waited);
    waited = 0;
    while (((sel == 0) ? d1 : d2) == 0 && waited < limit) begin
      @(negedge clk); waited++;
    end
    repeat (20) @(negedge clk);
  endtask

  initial begin
    int w;
    repeat (3) @(negedge clk);
    // Reset state
    check("R6 reset pull", int'(drv1), 0);
    check("R7 reset done", int'(done1), 0);
    check("R7 reset err", int'(err1), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    clr = 1'b0;

    // Sweep release point: 0 = lines idle at start, 1..11 = stuck for that many pulses.
    for (int k = 0; k <= exp_pulses(0) + 2; k++) begin
      clear_mon();
      stuck1 = (k != 0); rel1 = k;
      repeat (4) @(negedge clk);
      start1 = 1'b1; @(negedge clk); start1 = 1'b0;
      wait_done(0, 2000, w);
      if (w >= 2000) begin errors++; checks++; $display("FAIL watchdog k=%0d actual 1 expected 0", k); end
      if (k == 0) begin
        check("R1 no pulses when idle", p1, 0);
        check("R1 quick done", int'(w <= 4), 1);
        check("R1 no error", e1, 0);
      end else begin
        check("R2 pulse count", p1, exp_pulses(0));
        check("R3 low phase width", lb1, 0);
        check("R3 release phase width", hb1, 0);
        if (k <= exp_pulses(0)) check("R4 success after pulses", e1, 0);
        else begin
          check("R5 busy error", e1, 1);
          check("R5 timeout gap", g1, PHASE + TOC);
        end
      end
      check("R7 single done", d1, 1);
      stuck1 = 1'b0;
    end

    // SCL held low by the bus: recovery times out.
    clear_mon();
    hold1 = 1'b1;
    repeat (4) @(negedge clk);
    start1 = 1'b1; @(negedge clk); start1 = 1'b0;
    wait_done(0, 2000, w);
    check("R2 pulses with scl held", p1, exp_pulses(0));
    check("R5 error scl held", e1, 1);
    check("R5 gap scl held", g1, PHASE + TOC);
    check("R6 pull only in low phases", int'(drv1), 0);
    hold1 = 1'b0;

    // Second start in the middle of a run is ignored.
    clear_mon();
    stuck1 = 1'b1; rel1 = 3;
    repeat (4) @(negedge clk);
    start1 = 1'b1; @(negedge clk); start1 = 1'b0;
    repeat (30) @(negedge clk);
    start1 = 1'b1; @(negedge clk); start1 = 1'b0;
    wait_done(0, 2000, w);
    check("R8 pulse count unchanged", p1, exp_pulses(0));
    check("R8 one done", d1, 1);
    check("R8 no error", e1, 0);
    stuck1 = 1'b0;

    // Scaled count on the second copy, target stuck through all pulses.
    clear_mon();
    stuck2 = 1'b1; rel2 = exp_pulses(2);
    repeat (4) @(negedge clk);
    start2 = 1'b1; @(negedge clk); start2 = 1'b0;
    wait_done(1, 4000, w);
    check("R2 scaled pulse count", p2, exp_pulses(2));
    check("R3 scaled low width", lb2, 0);
    check("R4 scaled success", e2, 0);
    check("R7 scaled single done", d2, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule